// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits next to the 32-bit-wide transmit and receive FIFOs of a serial peripheral controller. It tracks how many bytes the receive FIFO holds and how many byte slots the transmit FIFO has free. It presents both counts in one 32-bit event word, together with two sticky condition flags: receive-not-empty and transmit-not-full. Software acknowledges a flag by writing the event word with a 1 in that flag's position. Writing all ones clears every flag at start-up.

A mask word enables each flag onto a single interrupt line, one bit at a time. The receive side is filled with up to four bytes per push, because the last word of a frame may be partial. It is drained one 32-bit word per pop; the final pop of a frame removes only the bytes that remain. The transmit side loses four free bytes per word loaded and regains the number of bytes the serial engine has shifted out. Both counts saturate between zero and the FIFO depth. The FIFO storage and the shift engine are not part of this block.

Top module: `spi_fifo_evt_irq`

## Requirements
- R1: While reset is held, the event word reads receive count 0, transmit free count DEPTH_BYTES and both flags 0; the mask word and `irq` read 0.
- R2: Event bits 29:24 hold the receive byte count. A push adds `rx_push_bytes`, where any value above 4 counts as 4 and 0 adds nothing. A pop removes 4 bytes, or all remaining bytes if fewer are held. The new value is visible one cycle after the clock edge that samples the push or pop.
- R3: Event bits 21:16 hold the transmit free byte count. A load removes 4 bytes, or all remaining bytes if fewer are free. A drain adds `tx_drain_bytes`, where any value above 4 counts as 4. The timing is the same as in R2.
- R4: Both counts saturate: neither goes below 0 nor above DEPTH_BYTES, including when an add and a remove happen in the same cycle.
- R5: Event bit 9 (receive not empty) becomes 1 one cycle after the receive count is nonzero. It then stays 1 until it is cleared, even if the FIFO empties.
- R6: Event bit 8 (transmit not full) becomes 1 one cycle after the transmit free count is nonzero. It then stays 1 until it is cleared.
- R7: A write to the event word clears each of bits 9 and 8 that is 1 in `wr_data` and leaves the other flag unchanged. Writes never change the count fields. Event bits 31:30, 23:22, 15:10 and 7:0 always read 0.
- R8: A flag cleared while its condition still holds reads 0 for one cycle and is set again in the following cycle.
- R9: A mask write stores `wr_data` bits 9 and 8 at the same positions of the mask word. All other mask bits read 0.
- R10: `irq` is 1 exactly one cycle after any event flag is 1 while its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Receive FIFO accepted a word |
| rx_push_bytes | input | 3 | Valid bytes in the pushed word (1 to 4) |
| rx_pop | input | 1 | One receive word read out |
| tx_load | input | 1 | One transmit word written in |
| tx_drain | input | 1 | Serial engine consumed transmit bytes |
| tx_drain_bytes | input | 3 | Bytes consumed (1 to 4) |
| evt_wr | input | 1 | Write-one-to-clear strobe for the event word |
| msk_wr | input | 1 | Write strobe for the mask word |
| wr_data | input | 32 | Write data for either word |
| evt_word | output | 32 | Counts and flags |
| msk_word | output | 32 | Current mask |
| irq | output | 1 | Registered interrupt request |

## Verification
A count that drifts shows up in the corresponding event field in the cycle after the edge that caused it. Because the count feeds the flag condition, a count that wrongly stays at zero also holds back the not-empty or not-full flag by one more cycle. A flag that sets late, or that stays set through a clear, is visible in bits 9 and 8. With the mask bit enabled, the same error appears on `irq` one cycle after that. The bench compares every field, the mask word and `irq` against a cycle-accurate model on every cycle, so a wrong internal state is reported in the first cycle it reaches the ports.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int EVT_W      = 32;
    localparam int CNT_W      = 6;
    localparam int RX_CNT_LSB = 24;
    localparam int TX_CNT_LSB = 16;
    localparam int FLAG_LSB   = 8;   // bit 8 = transmit not full, bit 9 = receive not empty
    localparam int NUM_FLAGS  = 2;
    localparam int WORD_BYTES = 4;

    typedef enum logic [0:0] {
        FLG_TX_NF = 1'b0,
        FLG_RX_NE = 1'b1
    } flag_idx_e;
endpackage

// File: rtl/spi_fifo_level.sv
module spi_fifo_level #(
    parameter int DEPTH     = 32,
    parameter int RESET_VAL = 0,
    parameter int CNT_W     = spi_evt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [2:0]       inc_bytes,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] DEPTH_V = SUM_W'(DEPTH);
    localparam logic [SUM_W-1:0] STEP_V  = SUM_W'(spi_evt_pkg::WORD_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lvl_st_t;

    lvl_st_t          st_d, st_q;
    logic [SUM_W-1:0] add_v, total_v, rem_v;

    always_comb begin
        st_d    = st_q;
        add_v   = '0;
        if (inc_en)
            add_v = (inc_bytes > 3'd4) ? STEP_V : SUM_W'(inc_bytes);
        total_v = SUM_W'(st_q.cnt) + add_v;
        if (dec_en)
            rem_v = (total_v < STEP_V) ? '0 : total_v - STEP_V;
        else
            rem_v = total_v;
        if (rem_v > DEPTH_V)
            rem_v = DEPTH_V;
        st_d.cnt = rem_v[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: CNT_W'(RESET_VAL)};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(cnt) <= DEPTH_V);                                   // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !dec_en) |=> $stable(cnt));                    // R2
    AST_LEVEL_NO_RISE_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !inc_en) |=> (cnt <= $past(cnt)));              // R4
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags #(
    parameter int N = spi_evt_pkg::NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    typedef struct packed {
        logic [N-1:0] flag;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++)
            st_d.flag[i] = clr[i] ? 1'b0 : (st_q.flag[i] | cond[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> !flag[g]);                                  // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr[g]) |=> flag[g]);                     // R5
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (cond[g] && !clr[g]) |=> flag[g]);                     // R6
        AST_FLAG_RESET_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] ##1 (cond[g] && !clr[g])) |=> flag[g]);        // R8
    end
endmodule

// File: rtl/spi_fifo_evt_irq.sv
module spi_fifo_evt_irq #(
    parameter int DEPTH_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_push,
    input  logic [2:0]  rx_push_bytes,
    input  logic        rx_pop,
    input  logic        tx_load,
    input  logic        tx_drain,
    input  logic [2:0]  tx_drain_bytes,
    input  logic        evt_wr,
    input  logic        msk_wr,
    input  logic [31:0] wr_data,
    output logic [31:0] evt_word,
    output logic [31:0] msk_word,
    output logic        irq
);
    import spi_evt_pkg::*;

    localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] mask;
        logic                 irq;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic [CNT_W-1:0]     rx_cnt, tx_free;
    logic [NUM_FLAGS-1:0] cond, clr, flags;

    spi_fifo_level #(.DEPTH(DEPTH_BYTES), .RESET_VAL(0), .CNT_W(CNT_W)) i_rx_level (
        .clk(clk), .rst_n(rst_n),
        .inc_en(rx_push), .inc_bytes(rx_push_bytes), .dec_en(rx_pop),
        .cnt(rx_cnt)
    );

    spi_fifo_level #(.DEPTH(DEPTH_BYTES), .RESET_VAL(DEPTH_BYTES), .CNT_W(CNT_W)) i_tx_level (
        .clk(clk), .rst_n(rst_n),
        .inc_en(tx_drain), .inc_bytes(tx_drain_bytes), .dec_en(tx_load),
        .cnt(tx_free)
    );

    always_comb begin
        cond            = '0;
        cond[FLG_RX_NE] = (rx_cnt != '0);
        cond[FLG_TX_NF] = (tx_free != '0);
        clr             = evt_wr ? wr_data[FLAG_MSB:FLAG_LSB] : '0;
    end

    spi_evt_flags #(.N(NUM_FLAGS)) i_flags (
        .clk(clk), .rst_n(rst_n), .cond(cond), .clr(clr), .flag(flags)
    );

    always_comb begin
        st_d     = st_q;
        if (msk_wr)
            st_d.mask = wr_data[FLAG_MSB:FLAG_LSB];
        st_d.irq = |(flags & st_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        evt_word = '0;
        evt_word[RX_CNT_LSB +: CNT_W]  = rx_cnt;
        evt_word[TX_CNT_LSB +: CNT_W]  = tx_free;
        evt_word[FLAG_LSB +: NUM_FLAGS] = flags;
        msk_word = '0;
        msk_word[FLAG_LSB +: NUM_FLAGS] = st_q.mask;
    end

    assign irq = st_q.irq;

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_word[FLAG_MSB:FLAG_LSB] & msk_word[FLAG_MSB:FLAG_LSB])) |=> irq);   // R10
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(evt_word[FLAG_MSB:FLAG_LSB] & msk_word[FLAG_MSB:FLAG_LSB])) |=> !irq); // R10
    AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        msk_wr |=> (msk_word[FLAG_MSB:FLAG_LSB] == $past(wr_data[FLAG_MSB:FLAG_LSB]))); // R9
    AST_CNT_WRITE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && !rx_push && !rx_pop) |=> $stable(evt_word[RX_CNT_LSB +: CNT_W])); // R7
endmodule

// File: tb/test_spi_fifo_evt_irq.sv
`timescale 1ns/1ps
module test_spi_fifo_evt_irq;
    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 0, rx_pop = 0, tx_load = 0, tx_drain = 0, evt_wr = 0, msk_wr = 0;
    logic [2:0]  rx_push_bytes = 0, tx_drain_bytes = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] evt_word, msk_word;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int  m_rx, m_tx;
    bit  m_ne, m_nf, m_irq;
    bit [1:0] m_mask;

    always #2 clk = ~clk;

    spi_fifo_evt_irq #(.DEPTH_BYTES(D)) i_spi_fifo_evt_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_push_bytes(rx_push_bytes), .rx_pop(rx_pop),
        .tx_load(tx_load), .tx_drain(tx_drain), .tx_drain_bytes(tx_drain_bytes),
        .evt_wr(evt_wr), .msk_wr(msk_wr), .wr_data(wr_data),
        .evt_word(evt_word), .msk_word(msk_word), .irq(irq)
    );

    function automatic int f_lvl(int cur, bit inc, int ib, bit dec);
        int v = cur + (inc ? ((ib > 4) ? 4 : ib) : 0) - (dec ? 4 : 0);
        if (v < 0) v = 0;
        if (v > D) v = D;
        return v;
    endfunction

    function automatic logic [31:0] f_evt(int rx, int tx, bit ne, bit nf);
        logic [31:0] w = '0;
        w[29:24] = rx[5:0];
        w[21:16] = tx[5:0];
        w[9] = ne;
        w[8] = nf;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2", 32'(evt_word[29:24]), 32'(m_rx));
        chk("R3", 32'(evt_word[21:16]), 32'(m_tx));
        chk("R5", 32'(evt_word[9]), 32'(m_ne));
        chk("R6", 32'(evt_word[8]), 32'(m_nf));
        chk("R7", evt_word & 32'hC0C0_FCFF, 32'h0);
        chk("R9", msk_word, {22'h0, m_mask, 8'h0});
        chk("R10", 32'(irq), 32'(m_irq));
    endtask

    // one clock: inputs already driven; model advances at the edge; check at the falling edge
    task automatic step();
        bit [1:0] clr;
        @(posedge clk);
        clr    = evt_wr ? wr_data[9:8] : 2'b00;
        m_irq  = |({m_ne, m_nf} & m_mask);
        m_ne   = clr[1] ? 1'b0 : (m_ne | (m_rx != 0));
        m_nf   = clr[0] ? 1'b0 : (m_nf | (m_tx != 0));
        if (msk_wr) m_mask = wr_data[9:8];
        m_rx   = f_lvl(m_rx, rx_push, int'(rx_push_bytes), rx_pop);
        m_tx   = f_lvl(m_tx, tx_drain, int'(tx_drain_bytes), tx_load);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        rx_push = 0; rx_pop = 0; tx_load = 0; tx_drain = 0; evt_wr = 0; msk_wr = 0;
        rx_push_bytes = 0; tx_drain_bytes = 0; wr_data = 0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", evt_word, f_evt(0, D, 0, 0));
        chk("R1", msk_word, 32'h0);
        chk("R1", 32'(irq), 32'h0);
        m_rx = 0; m_tx = D; m_ne = 0; m_nf = 0; m_irq = 0; m_mask = 0;
        rst_n = 1'b1;
        step();
        step();
        // clear everything, enable both interrupts
        idle(); evt_wr = 1; wr_data = 32'hFFFF_FFFF; step();
        idle(); msk_wr = 1; wr_data = 32'h0000_0300; step();
        idle();
        // R4: fill the receive side past its depth
        for (int i = 0; i < 12; i++) begin rx_push = 1; rx_push_bytes = 3'd4; step(); end
        idle(); step();
        chk("R4", 32'(evt_word[29:24]), D);
        // R2: push a partial word then drain, last pop takes only the remainder
        for (int i = 0; i < 8; i++) begin idle(); rx_pop = 1; step(); end
        idle(); rx_push = 1; rx_push_bytes = 3'd3; step();
        idle(); rx_pop = 1; step();
        idle(); step();
        chk("R2", 32'(evt_word[29:24]), 0);
        // R5: flag stays set after the FIFO empties
        chk("R5", 32'(evt_word[9]), 1);
        // R7: a write with bit 9 only clears bit 9, counts unchanged
        idle(); rx_push = 1; rx_push_bytes = 3'd2; step();
        idle(); evt_wr = 1; wr_data = 32'h3F3F_0200; step();
        chk("R7", 32'(evt_word[9]), 0);
        chk("R7", 32'(evt_word[29:24]), 2);
        // R8: condition still holds, so bit 9 returns one cycle later
        idle(); step();
        chk("R8", 32'(evt_word[9]), 1);
        // R3: empty the transmit side, then drain past depth
        for (int i = 0; i < 10; i++) begin idle(); tx_load = 1; step(); end
        idle(); evt_wr = 1; wr_data = 32'h0000_0100; step();
        idle(); step();
        chk("R6", 32'(evt_word[8]), 0);
        for (int i = 0; i < 12; i++) begin idle(); tx_drain = 1; tx_drain_bytes = 3'd7; step(); end
        idle(); step();
        chk("R3", 32'(evt_word[21:16]), D);
        // R10: masking off stops the request one cycle after the mask changes
        idle(); msk_wr = 1; wr_data = 32'hFFFF_FCFF; step();
        idle(); step();
        chk("R10", 32'(irq), 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            idle();
            rx_push = ($urandom % 3) == 0;
            rx_push_bytes = 3'($urandom % 6);
            rx_pop = ($urandom % 3) == 0;
            tx_load = ($urandom % 3) == 0;
            tx_drain = ($urandom % 3) == 0;
            tx_drain_bytes = 3'($urandom % 6);
            evt_wr = ($urandom % 8) == 0;
            msk_wr = ($urandom % 16) == 0;
            wr_data = $urandom;
            step();
        end
        idle(); step();
        done = 1;
        report();
        $finish;
    end
endmodule